// File: doc/BRIEF.md
# Stream Pipeline Stage with Ready Latency One

This block is a single registered stage on a streaming data path. Each beat carries a data word and four control flags: valid, sync, start-of-packet and end-of-packet. Flow control uses a ready signal with a latency of one cycle. The upstream source may therefore present one more valid beat in the cycle after ready falls. The stage passes the downstream ready back upstream unchanged. It catches that late beat and keeps it so that nothing is lost.

The data word of the late beat stays in the output data register. Each of its control flags is remembered in its own hold flag. When ready returns, the stage emits the held beat on the registered output at once. It does not wait for a new input beat, so a trailing end-of-packet leaves straight away and is not stuck behind the next packet's first beat.

The stage also exposes two combinational views of the output. The "pending" view is what the stage wants to emit. The "next" view is the pending view gated by ready, and the output register loads it on every clock edge. Logic whose ready depends on the stage's output can use the pending view without forming a combinational loop.

Top module: `rl1_stream_stage`

## Requirements
- R1: `up_ready` equals `dn_ready` in the same cycle, with no register between them.
- R2: `pend_data` equals `in_data` when `in_valid` is high. Otherwise it equals the current `out_data`.
- R3: Each pending flag (valid, sync, sop, eop) is the OR of the matching input flag and its hold flag. A hold flag is only visible through the pending outputs.
- R4: Each next flag equals the pending flag ANDed with `dn_ready`. `next_data` equals `pend_data`. `out_valid` is never high unless `dn_ready` was high in the previous cycle.
- R5: On every clock edge, `out_data` and the four output flags take the values that the next outputs had just before that edge.
- R6: A valid beat that arrives while `dn_ready` is low is not lost. It appears on `out_valid` with the same `out_data` one cycle after the first cycle in which `dn_ready` is high again.
- R7: Held sync, sop and eop flags are emitted together with the held beat as soon as ready returns, with no new input beat required.
- R8: A hold flag is set when its input flag is high while `dn_ready` is low. It stays set while `dn_ready` stays low, and it clears in any cycle in which `dn_ready` is high. With no late beat, no hold flag is set.
- R9: With `dn_ready` held high, the outputs repeat the inputs delayed by exactly one cycle.
- R10: A synchronous reset, `rst` high at a clock edge, clears all hold flags, all output flags and `out_data`.
- R11: `in_valid` and the held valid flag are never high in the same cycle when the upstream obeys the one-cycle ready latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Input beat data |
| in_valid | input | 1 | Input beat valid |
| in_sync | input | 1 | Input sync flag |
| in_sop | input | 1 | Input start-of-packet flag |
| in_eop | input | 1 | Input end-of-packet flag |
| up_ready | output | 1 | Ready to the upstream source, copy of dn_ready |
| dn_ready | input | 1 | Ready from the downstream sink, latency one |
| out_data | output | DATA_W | Registered output data |
| out_valid | output | 1 | Registered output valid |
| out_sync | output | 1 | Registered output sync |
| out_sop | output | 1 | Registered output start-of-packet |
| out_eop | output | 1 | Registered output end-of-packet |
| pend_data | output | DATA_W | Pending data, not gated by ready |
| pend_valid | output | 1 | Pending valid, not gated by ready |
| pend_sync | output | 1 | Pending sync, not gated by ready |
| pend_sop | output | 1 | Pending start-of-packet, not gated by ready |
| pend_eop | output | 1 | Pending end-of-packet, not gated by ready |
| next_data | output | DATA_W | Data the output register loads at the next edge |
| next_valid | output | 1 | Pending valid ANDed with dn_ready |
| next_sync | output | 1 | Pending sync ANDed with dn_ready |
| next_sop | output | 1 | Pending start-of-packet ANDed with dn_ready |
| next_eop | output | 1 | Pending end-of-packet ANDed with dn_ready |

## Verification
The assertions check on every cycle that:
- hold flags set, stick and clear according to ready;
- an output beat never appears unless ready was high one cycle earlier;
- a held beat reaches the output in the cycle after ready returns, with its data unchanged;
- the register tracks the next view;
- a new input beat never overlaps a held one.

Only the bench's scenarios show that the data word emitted after a stall is the word that arrived late. They also show that a lone trailing end-of-packet is flushed without a follow-up beat, that an always-ready stream becomes a plain one-cycle delay, and that a reset in the middle of a stall discards the held beat.

// File: rtl/rl1_stage_pkg.sv
package rl1_stage_pkg;
   // Number of per-beat control flags carried beside the data word
   localparam int NUM_FLAGS = 4;
   // Bit positions of the flags inside a flag vector
   localparam int F_VALID = 0;
   localparam int F_SYNC  = 1;
   localparam int F_SOP   = 2;
   localparam int F_EOP   = 3;
   typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/rl1_hold_bank.sv
module rl1_hold_bank #(
   parameter int NF = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ready,
   input  logic [NF-1:0] in_flags,
   output logic [NF-1:0] hold_flags
);
   if (NF < 1) begin : g_bad_nf
      $error("rl1_hold_bank: NF must be at least 1");
   end

   // One independent hold register per control flag
   for (genvar i = 0; i < NF; i++) begin : g_flag
      logic hold_q;
      always_ff @(posedge clk) begin
         if (rst)
            hold_q <= 1'b0;
         else if (ready)
            hold_q <= 1'b0;
         else if (in_flags[i])
            hold_q <= 1'b1;
      end
      assign hold_flags[i] = hold_q;

      // R8: ready high always empties the hold
      assert_hold_clear_R8: assert property (@(posedge clk) disable iff (rst)
         ready |=> !hold_flags[i]);
      // R8: a flag seen while stalled is captured
      assert_hold_capture_R8: assert property (@(posedge clk) disable iff (rst)
         (!ready && in_flags[i]) |=> hold_flags[i]);
      // R8: a held flag persists through the stall
      assert_hold_keep_R8: assert property (@(posedge clk) disable iff (rst)
         (!ready && hold_flags[i]) |=> hold_flags[i]);
   end
endmodule

// File: rtl/rl1_pend_mux.sv
module rl1_pend_mux
   import rl1_stage_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int NF     = NUM_FLAGS
) (
   input  logic              ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic [NF-1:0]     in_flags,
   input  logic [NF-1:0]     hold_flags,
   input  logic [DATA_W-1:0] reg_data,
   output logic [DATA_W-1:0] pend_data,
   output logic [NF-1:0]     pend_flags,
   output logic [NF-1:0]     next_flags
);
   if (NF <= F_EOP) begin : g_bad_nf
      $error("rl1_pend_mux: NF too small for the flag indices");
   end

   always_comb begin
      // A live input beat wins; otherwise the held word in the output register
      pend_data  = in_flags[F_VALID] ? in_data : reg_data;
      pend_flags = in_flags | hold_flags;
      next_flags = pend_flags & {NF{ready}};
   end
endmodule

// File: rtl/rl1_out_reg.sv
module rl1_out_reg #(
   parameter int DATA_W     = 16,
   parameter int NF         = 4,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] next_data,
   input  logic [NF-1:0]     next_flags,
   output logic [DATA_W-1:0] out_data,
   output logic [NF-1:0]     out_flags
);
   always_ff @(posedge clk) begin
      if (rst) out_flags <= '0;
      else     out_flags <= next_flags;
   end

   // Variant choice: data register with or without reset
   if (RESET_DATA) begin : g_data_rst
      always_ff @(posedge clk) begin
         if (rst) out_data <= '0;
         else     out_data <= next_data;
      end
   end else begin : g_data_free
      always_ff @(posedge clk) out_data <= next_data;
   end
endmodule

// File: rtl/rl1_stream_stage.sv
module rl1_stream_stage
   import rl1_stage_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   input  logic              in_sync,
   input  logic              in_sop,
   input  logic              in_eop,
   output logic              up_ready,
   input  logic              dn_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   output logic              out_sync,
   output logic              out_sop,
   output logic              out_eop,
   output logic [DATA_W-1:0] pend_data,
   output logic              pend_valid,
   output logic              pend_sync,
   output logic              pend_sop,
   output logic              pend_eop,
   output logic [DATA_W-1:0] next_data,
   output logic              next_valid,
   output logic              next_sync,
   output logic              next_sop,
   output logic              next_eop
);
   localparam int NF = NUM_FLAGS;

   if (DATA_W < 1) begin : g_bad_width
      $error("rl1_stream_stage: DATA_W must be at least 1");
   end

   flag_vec_t in_f, hold_f, pend_f, next_f, out_f;
   logic [DATA_W-1:0] pend_d;

   // Ready goes upstream untouched: the latency stays one cycle
   assign up_ready = dn_ready;

   always_comb begin
      in_f          = '0;
      in_f[F_VALID] = in_valid;
      in_f[F_SYNC]  = in_sync;
      in_f[F_SOP]   = in_sop;
      in_f[F_EOP]   = in_eop;
   end

   rl1_hold_bank #(.NF(NF)) u_hold (
      .clk        (clk),
      .rst        (rst),
      .ready      (dn_ready),
      .in_flags   (in_f),
      .hold_flags (hold_f)
   );

   rl1_pend_mux #(.DATA_W(DATA_W), .NF(NF)) u_pend (
      .ready      (dn_ready),
      .in_data    (in_data),
      .in_flags   (in_f),
      .hold_flags (hold_f),
      .reg_data   (out_data),
      .pend_data  (pend_d),
      .pend_flags (pend_f),
      .next_flags (next_f)
   );

   rl1_out_reg #(.DATA_W(DATA_W), .NF(NF), .RESET_DATA(RESET_DATA)) u_oreg (
      .clk        (clk),
      .rst        (rst),
      .next_data  (pend_d),
      .next_flags (next_f),
      .out_data   (out_data),
      .out_flags  (out_f)
   );

   assign pend_data  = pend_d;
   assign next_data  = pend_d;
   assign pend_valid = pend_f[F_VALID];
   assign pend_sync  = pend_f[F_SYNC];
   assign pend_sop   = pend_f[F_SOP];
   assign pend_eop   = pend_f[F_EOP];
   assign next_valid = next_f[F_VALID];
   assign next_sync  = next_f[F_SYNC];
   assign next_sop   = next_f[F_SOP];
   assign next_eop   = next_f[F_EOP];
   assign out_valid  = out_f[F_VALID];
   assign out_sync   = out_f[F_SYNC];
   assign out_sop    = out_f[F_SOP];
   assign out_eop    = out_f[F_EOP];

   // R4: nothing is emitted unless ready was high one cycle earlier
   assert_emit_needs_ready_R4: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(dn_ready));
   // R5: the register follows the next view
   assert_reg_tracks_next_R5: assert property (@(posedge clk) disable iff (rst)
      next_valid |=> out_valid);
   // R6: a held beat leaves right after ready returns, its word intact
   assert_held_flushed_R6: assert property (@(posedge clk) disable iff (rst)
      (hold_f[F_VALID] && dn_ready) |=> (out_valid && out_data == $past(out_data)));
   // R7: a held end-of-packet is flushed without a new beat
   assert_eop_flushed_R7: assert property (@(posedge clk) disable iff (rst)
      (hold_f[F_EOP] && dn_ready) |=> out_eop);
   // R10: reset empties every output flag
   assert_reset_clear_R10: assert property (@(posedge clk)
      rst |=> (out_f == '0 && hold_f == '0));
   // R11: a live beat never coincides with a held one
   assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && hold_f[F_VALID]));
endmodule

// File: tb/rl1_stream_stage_test.sv
module rl1_stream_stage_test;
   localparam int DW = 16;
   localparam int NV = 14;
   // {ready, in VSPE, in_data, exp pend VSPE, exp pend_data, exp out VSPE, exp out_data}
   localparam logic [60:0] VEC [NV] = '{
      {1'b1, 4'b1010, 16'h0011, 4'b1010, 16'h0011, 4'b1010, 16'h0011},
      {1'b1, 4'b1000, 16'h0022, 4'b1000, 16'h0022, 4'b1000, 16'h0022},
      {1'b0, 4'b1001, 16'h0033, 4'b1001, 16'h0033, 4'b0000, 16'h0033},
      {1'b0, 4'b0000, 16'h00FF, 4'b1001, 16'h0033, 4'b0000, 16'h0033},
      {1'b1, 4'b0000, 16'h0EEE, 4'b1001, 16'h0033, 4'b1001, 16'h0033},
      {1'b1, 4'b0000, 16'h0ABC, 4'b0000, 16'h0033, 4'b0000, 16'h0033},
      {1'b1, 4'b1110, 16'h0044, 4'b1110, 16'h0044, 4'b1110, 16'h0044},
      {1'b0, 4'b1000, 16'h0055, 4'b1000, 16'h0055, 4'b0000, 16'h0055},
      {1'b1, 4'b0000, 16'h0000, 4'b1000, 16'h0055, 4'b1000, 16'h0055},
      {1'b1, 4'b1001, 16'h0066, 4'b1001, 16'h0066, 4'b1001, 16'h0066},
      {1'b0, 4'b0000, 16'h0077, 4'b0000, 16'h0066, 4'b0000, 16'h0066},
      {1'b0, 4'b0000, 16'h0078, 4'b0000, 16'h0066, 4'b0000, 16'h0066},
      {1'b1, 4'b0000, 16'h0079, 4'b0000, 16'h0066, 4'b0000, 16'h0066},
      {1'b1, 4'b0100, 16'h0088, 4'b0100, 16'h0066, 4'b0100, 16'h0066}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [DW-1:0] in_data = '0;
   logic in_valid = 1'b0, in_sync = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
   logic dn_ready = 1'b0;
   logic up_ready;
   logic [DW-1:0] out_data, pend_data, next_data;
   logic out_valid, out_sync, out_sop, out_eop;
   logic pend_valid, pend_sync, pend_sop, pend_eop;
   logic next_valid, next_sync, next_sop, next_eop;
   int nchk = 0, nfail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rl1_stream_stage #(.DATA_W(DW)) uut (
      .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
      .in_sync(in_sync), .in_sop(in_sop), .in_eop(in_eop),
      .up_ready(up_ready), .dn_ready(dn_ready),
      .out_data(out_data), .out_valid(out_valid), .out_sync(out_sync),
      .out_sop(out_sop), .out_eop(out_eop),
      .pend_data(pend_data), .pend_valid(pend_valid), .pend_sync(pend_sync),
      .pend_sop(pend_sop), .pend_eop(pend_eop),
      .next_data(next_data), .next_valid(next_valid), .next_sync(next_sync),
      .next_sop(next_sop), .next_eop(next_eop)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic rdy, input logic [3:0] f, input logic [DW-1:0] d);
      dn_ready = rdy;
      {in_valid, in_sync, in_sop, in_eop} = f;
      in_data = d;
   endtask

   function automatic logic [3:0] outf();
      return {out_valid, out_sync, out_sop, out_eop};
   endfunction
   function automatic logic [3:0] pendf();
      return {pend_valid, pend_sync, pend_sop, pend_eop};
   endfunction
   function automatic logic [3:0] nextf();
      return {next_valid, next_sync, next_sop, next_eop};
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R10 reset out flags", 32'(outf()), 32'h0);
      chk("R10 reset out data", 32'(out_data), 32'h0);
      @(negedge clk);
      rst = 1'b0;

      // Table walk
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VEC[i][60], VEC[i][59:56], VEC[i][55:40]);
         #1;
         chk("R1 ready pass", 32'(up_ready), 32'(VEC[i][60]));
         chk("R3 pending flags", 32'(pendf()), 32'(VEC[i][39:36]));
         chk("R2 pending data", 32'(pend_data), 32'(VEC[i][35:20]));
         chk("R4 next flags", 32'(nextf()), VEC[i][60] ? 32'(VEC[i][39:36]) : 32'h0);
         chk("R4 next data", 32'(next_data), 32'(VEC[i][35:20]));
         @(posedge clk);
         #1;
         chk("R5 R6 R7 out flags", 32'(outf()), 32'(VEC[i][19:16]));
         chk("R5 R6 out data", 32'(out_data), 32'(VEC[i][15:0]));
      end

      // R8: long stall holds a late end-of-packet beat, then flushes it
      @(negedge clk); drive(1'b1, 4'b1000, 16'h1111);
      @(negedge clk); drive(1'b0, 4'b1001, 16'h2222);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk); drive(1'b0, 4'b0000, 16'h3333);
         #1;
         chk("R8 hold kept valid/eop", 32'(pendf()), 32'b1001);
         chk("R8 stalled out_valid", 32'(out_valid), 32'h0);
      end
      @(negedge clk); drive(1'b1, 4'b0000, 16'h4444);
      @(posedge clk); #1;
      chk("R7 flushed eop", 32'(outf()), 32'b1001);
      chk("R6 flushed data", 32'(out_data), 32'h2222);
      @(negedge clk); drive(1'b1, 4'b0000, 16'h5555);
      #1;
      chk("R8 hold cleared", 32'(pendf()), 32'h0);
      @(posedge clk); #1;
      chk("R6 single emit", 32'(out_valid), 32'h0);

      // R10: reset during a stall drops the held beat
      @(negedge clk); drive(1'b0, 4'b1011, 16'h6666);
      @(negedge clk); drive(1'b0, 4'b0000, 16'h0); rst = 1'b1;
      @(posedge clk); #1;
      chk("R10 out flags after reset", 32'(outf()), 32'h0);
      chk("R10 out data after reset", 32'(out_data), 32'h0);
      @(negedge clk); rst = 1'b0; drive(1'b0, 4'b0000, 16'h0);
      #1;
      chk("R10 hold cleared by reset", 32'(pendf()), 32'h0);

      // R9: ready held high gives a plain one-cycle delay
      @(negedge clk); drive(1'b1, 4'b0000, 16'h0);
      for (int k = 0; k < 20; k++) begin
         logic [3:0] f;
         logic [DW-1:0] d;
         f = {1'b1, k[2], (k % 5) == 0, (k % 5) == 4};
         d = DW'(16'hA000 + k * 7);
         @(negedge clk); drive(1'b1, f, d);
         @(posedge clk); #1;
         chk("R9 plain register flags", 32'(outf()), 32'(f));
         chk("R9 plain register data", 32'(out_data), 32'(d));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule